// File: doc/BRIEF.md
# Serial Bus Length Field Slot Engine

This block handles the eight-bit length field of a frame on a multi-master serial bus. It works one bit slot at a time. A bit-timing layer gives it a strobe at each sample point together with the sampled line level. The block returns the level that this node should place on the line during the current slot. When a field begins, a direction input is captured. It selects whether this node sends the length value or listens for it. A broadcast input is captured at the same moment and turns the acknowledge slot off.

After the eight length bits comes one parity bit, followed, in non-broadcast frames only, by one acknowledge slot. The block finishes every field in one of two ways. It raises a one-cycle proceed pulse together with the decoded byte count, after which the data field may start. Or it raises a one-cycle quit pulse, which sends both nodes back to the monitor state. A length value of zero stands for the largest count. A long transfer that needs more frames gets a fresh length value from outside for each frame; the block never changes the value it is given.

The interface is paced by bit slots, so no flow control applies. Every decision is taken on a bit strobe, and the only holding-off is that a start request is refused while a field is in flight. This is why all pins are plain level or pulse signals and none carries a valid/ready pair.

Top module: `lenfield_slot`

## Requirements
- R1: A synchronous reset, or the abort input, brings the block to idle in the next cycle. In idle, drive_o is 1 (recessive), proceed_o and quit_o are 0, and strobes have no effect until a new start.
- R2: When this node is the sender (talk_i=1 at start), drive_o carries tx_len_i as captured at start. The most significant bit comes first, and the next bit is presented after each bit strobe. As a listener, drive_o stays 1 throughout the length bits.
- R3: In the ninth slot, a sender drives the even-parity bit. Its value makes the eight length bits plus parity hold an even number of ones.
- R4: A listener shifts in the line level at eight strobes, most significant bit first. On the proceed pulse, count_o equals the received value.
- R5: count_o is 9 bits wide. The values 1..255 decode to themselves, and the value 0 decodes to 256.
- R6: If a listener samples a parity bit that makes the ones count odd, it pulses quit_o in the cycle after that strobe, drives no acknowledge, and returns to idle.
- R7: A listener in a non-broadcast frame with good parity drives 0 during the acknowledge slot. It pulses proceed_o after the acknowledge strobe.
- R8: A sender in a non-broadcast frame samples the acknowledge slot. Level 0 gives a proceed pulse; level 1 gives a quit pulse.
- R9: A broadcast frame has no acknowledge slot. The field ends at the parity strobe, and a listener never drives 0.
- R10: start_i is ignored while a field is in progress. bit_stb_i is ignored while idle.
- R11: proceed_o and quit_o are single-cycle pulses and are never high together. count_o changes only on the edge that raises proceed_o.
- R12: An abort in the same cycle as a deciding strobe wins. Neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort_i | input | 1 | Return to idle at once, no pulse |
| start_i | input | 1 | Begin a length field (accepted only in idle) |
| talk_i | input | 1 | 1: this node sends the field; 0: it listens (captured at start) |
| bcast_i | input | 1 | 1: broadcast frame, no acknowledge slot (captured at start) |
| tx_len_i | input | 8 | Length value to send (captured at start) |
| bit_stb_i | input | 1 | Sample point of the current bit slot |
| line_i | input | 1 | Sampled bus level at the strobe |
| drive_o | output | 1 | Level to place on the bus in the current slot (1 = recessive) |
| proceed_o | output | 1 | One-cycle pulse: field accepted, go to data |
| quit_o | output | 1 | One-cycle pulse: field rejected, back to monitor |
| count_o | output | 9 | Decoded byte count, 1..256, updated with proceed_o |

## Verification
Two events can land on the same clock edge: an external abort and the strobe that would decide the field, whether that strobe is the parity strobe of a broadcast frame or the acknowledge strobe. The bench provokes this by holding abort_i high during that deciding strobe. It then expects no proceed or quit pulse and an unchanged count_o, then a recessive drive_o, and finally no pulse from later strobes. A second overlap is a start request raised in the middle of a field. The bench judges it by confirming that the field in progress still ends with the expected bits, the expected pulse and the expected count.

// File: rtl/lenfield_pkg.sv
package lenfield_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEN  = 2'd1,
    ST_PAR  = 2'd2,
    ST_ACK  = 2'd3
  } lf_state_e;
endpackage

// File: rtl/lenfield_bitpath.sv
module lenfield_bitpath #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             talk_i,
  input  logic [LEN_W-1:0] tx_val_i,
  input  logic             shift_i,
  input  logic             talk_q_i,
  input  logic             line_i,
  output logic [LEN_W-1:0] sr_o,
  output logic             par_o,
  output logic             last_o
);
  localparam int SLOT_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LEN_W - 1);

  logic [LEN_W-1:0]  sr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              next_bit;

  // sender rotates its own value so it ends back in place; listener shifts the line in
  assign next_bit = talk_q_i ? sr_q[LEN_W-1] : line_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      slot_q <= '0;
    end else if (load_i) begin
      sr_q   <= talk_i ? tx_val_i : '0;
      slot_q <= '0;
    end else if (shift_i) begin
      sr_q   <= {sr_q[LEN_W-2:0], next_bit};
      slot_q <= slot_q + 1'b1;
    end
  end

  assign sr_o   = sr_q;
  assign par_o  = ^sr_q;
  assign last_o = (slot_q == LAST_SLOT);
endmodule

// File: rtl/lenfield_ctl.sv
module lenfield_ctl
  import lenfield_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             talk_i,
  input  logic             bcast_i,
  input  logic             bit_stb_i,
  input  logic             line_i,
  input  logic [LEN_W-1:0] sr_i,
  input  logic             par_i,
  input  logic             last_i,
  output lf_state_e        st_o,
  output logic             talk_q_o,
  output logic             bcast_q_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             proceed_o,
  output logic             quit_o,
  output logic [CNT_W-1:0] count_o
);
  lf_state_e        st_q;
  logic             talk_q, bcast_q, proceed_q, quit_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] decoded;
  logic             par_bad;

  // zero encodes the full 2**LEN_W byte count
  assign decoded = (sr_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, sr_i};
  assign par_bad = par_i ^ line_i;

  assign load_o  = (st_q == ST_IDLE) && start_i && !abort_i;
  assign shift_o = (st_q == ST_LEN) && bit_stb_i && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      talk_q    <= 1'b0;
      bcast_q   <= 1'b0;
      proceed_q <= 1'b0;
      quit_q    <= 1'b0;
      count_q   <= '0;
    end else if (abort_i) begin
      st_q      <= ST_IDLE;
      proceed_q <= 1'b0;
      quit_q    <= 1'b0;
    end else begin
      proceed_q <= 1'b0;
      quit_q    <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_LEN;
            talk_q  <= talk_i;
            bcast_q <= bcast_i;
          end
        end
        ST_LEN: begin
          if (bit_stb_i && last_i) st_q <= ST_PAR;
        end
        ST_PAR: begin
          if (bit_stb_i) begin
            if (!talk_q && par_bad) begin
              quit_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (bcast_q) begin
              proceed_q <= 1'b1;
              count_q   <= decoded;
              st_q      <= ST_IDLE;
            end else begin
              st_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (bit_stb_i) begin
            if (talk_q && line_i) begin
              quit_q <= 1'b1;
            end else begin
              proceed_q <= 1'b1;
              count_q   <= decoded;
            end
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign talk_q_o  = talk_q;
  assign bcast_q_o = bcast_q;
  assign proceed_o = proceed_q;
  assign quit_o    = quit_q;
  assign count_o   = count_q;
endmodule

// File: rtl/lenfield_drive.sv
module lenfield_drive
  import lenfield_pkg::*;
(
  input  lf_state_e st_i,
  input  logic      talk_q_i,
  input  logic      msb_i,
  input  logic      par_i,
  output logic      drive_o
);
  always_comb begin
    drive_o = 1'b1;
    unique case (st_i)
      ST_LEN:  drive_o = talk_q_i ? msb_i : 1'b1;
      ST_PAR:  drive_o = talk_q_i ? par_i : 1'b1;
      ST_ACK:  drive_o = talk_q_i;   // listener pulls low to acknowledge
      default: drive_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lenfield_slot.sv
module lenfield_slot
  import lenfield_pkg::*;
#(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             talk_i,
  input  logic             bcast_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic             bit_stb_i,
  input  logic             line_i,
  output logic             drive_o,
  output logic             proceed_o,
  output logic             quit_o,
  output logic [CNT_W-1:0] count_o
);
  lf_state_e        st_w;
  logic             talk_q_w, bcast_q_w, load_w, shift_w, par_w, last_w;
  logic [LEN_W-1:0] sr_w;

  lenfield_bitpath #(.LEN_W(LEN_W)) bitpath_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .talk_i   (talk_i),
    .tx_val_i (tx_len_i),
    .shift_i  (shift_w),
    .talk_q_i (talk_q_w),
    .line_i   (line_i),
    .sr_o     (sr_w),
    .par_o    (par_w),
    .last_o   (last_w)
  );

  lenfield_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .abort_i   (abort_i),
    .start_i   (start_i),
    .talk_i    (talk_i),
    .bcast_i   (bcast_i),
    .bit_stb_i (bit_stb_i),
    .line_i    (line_i),
    .sr_i      (sr_w),
    .par_i     (par_w),
    .last_i    (last_w),
    .st_o      (st_w),
    .talk_q_o  (talk_q_w),
    .bcast_q_o (bcast_q_w),
    .load_o    (load_w),
    .shift_o   (shift_w),
    .proceed_o (proceed_o),
    .quit_o    (quit_o),
    .count_o   (count_o)
  );

  lenfield_drive drive_i (
    .st_i     (st_w),
    .talk_q_i (talk_q_w),
    .msb_i    (sr_w[LEN_W-1]),
    .par_i    (par_w),
    .drive_o  (drive_o)
  );
endmodule

// File: rtl/lenfield_slot_chk.sv
module lenfield_slot_chk
  import lenfield_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             abort_i,
  input logic             bit_stb_i,
  input logic             drive_o,
  input logic             proceed_o,
  input logic             quit_o,
  input logic [CNT_W-1:0] count_o,
  input lf_state_e        st,
  input logic             talk_q,
  input logic             bcast_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {(CNT_W-1){1'b0}}};

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst) !(proceed_o && quit_o)); // R11
  AST_PROCEED_ONE: assert property (@(posedge clk) disable iff (rst) proceed_o |=> !proceed_o); // R11
  AST_QUIT_ONE: assert property (@(posedge clk) disable iff (rst) quit_o |=> !quit_o); // R11
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst) !proceed_o |-> $stable(count_o)); // R11
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) proceed_o |-> (count_o != '0 && count_o <= CNT_MAX)); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst) abort_i |=> (drive_o && !proceed_o && !quit_o)); // R12
  AST_DECIDE_ON_STB: assert property (@(posedge clk) disable iff (rst) (proceed_o || quit_o) |-> $past(bit_stb_i)); // R10
  AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (rst) (st != ST_IDLE && !talk_q && bcast_q) |-> drive_o); // R9
  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> drive_o); // R1
endmodule

bind lenfield_slot lenfield_slot_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .abort_i   (abort_i),
  .bit_stb_i (bit_stb_i),
  .drive_o   (drive_o),
  .proceed_o (proceed_o),
  .quit_o    (quit_o),
  .count_o   (count_o),
  .st        (st_w),
  .talk_q    (talk_q_w),
  .bcast_q   (bcast_q_w)
);

// File: tb/lenfield_slot_tb_top.sv
`timescale 1ns/1ps
module lenfield_slot_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       abort_i = 1'b0, start_i = 1'b0, talk_i = 1'b0, bcast_i = 1'b0;
  logic [7:0] tx_len_i = 8'h00;
  logic       bit_stb_i = 1'b0, line_i = 1'b1;
  logic       drive_o, proceed_o, quit_o;
  logic [8:0] count_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lenfield_slot dut_i (
    .clk(clk), .rst(rst), .abort_i(abort_i), .start_i(start_i), .talk_i(talk_i),
    .bcast_i(bcast_i), .tx_len_i(tx_len_i), .bit_stb_i(bit_stb_i), .line_i(line_i),
    .drive_o(drive_o), .proceed_o(proceed_o), .quit_o(quit_o), .count_o(count_o)
  );

  function automatic int exp_count(input logic [7:0] v);
    return (v == 8'h00) ? 256 : int'(v);
  endfunction

  function automatic logic even_par(input logic [7:0] v);
    return ^v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one bit slot: optional gap, strobe for one cycle, read pulses on the next negedge
  task automatic strobe(input logic lv, input logic ab, output logic p, output logic q);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    bit_stb_i = 1'b1; line_i = lv; abort_i = ab;
    @(negedge clk);
    p = proceed_o; q = quit_o;
    bit_stb_i = 1'b0; line_i = 1'b1; abort_i = 1'b0;
  endtask

  task automatic run_field(input bit tk, input bit bc, input logic [7:0] len,
                           input bit badp, input bit nack, input bit mid_start,
                           input bit abort_dec);
    logic p, q, pe;
    logic [8:0] cnt_before;
    pe = even_par(len);
    @(negedge clk);
    start_i = 1'b1; talk_i = tk; bcast_i = bc; tx_len_i = len;
    @(negedge clk);
    start_i = 1'b0; talk_i = ~tk; bcast_i = ~bc; tx_len_i = ~len;   // captured values must hold
    for (int i = 7; i >= 0; i--) begin
      chk(drive_o === (tk ? len[i] : 1'b1), "R2 length bit drive", drive_o, tk ? len[i] : 1);
      if (mid_start && i == 4) start_i = 1'b1;
      strobe(len[i], 1'b0, p, q);
      start_i = 1'b0;
      chk(!p && !q, "R10 no pulse during length bits", {p, q}, 0);
    end
    if (tk) chk(drive_o === pe, "R3 parity drive", drive_o, pe);
    else    chk(drive_o === 1'b1, "R6 listener parity slot recessive", drive_o, 1);
    cnt_before = count_o;
    if (abort_dec && bc) begin
      strobe(tk ? pe : pe, 1'b1, p, q);
      chk(!p && !q, "R12 abort beats parity decision", {p, q}, 0);
      chk(count_o == cnt_before, "R12 count unchanged", count_o, cnt_before);
      chk(drive_o === 1'b1, "R12 idle after abort", drive_o, 1);
      strobe(1'b0, 1'b0, p, q);
      chk(!p && !q, "R1 strobe after abort ignored", {p, q}, 0);
      return;
    end
    strobe(tk ? pe : (pe ^ badp), 1'b0, p, q);
    if (!tk && badp) begin
      chk(q && !p, "R6 bad parity quits", {p, q}, 1);
      chk(count_o == cnt_before, "R11 count held on quit", count_o, cnt_before);
      chk(drive_o === 1'b1, "R6 no acknowledge driven", drive_o, 1);
      return;
    end
    if (bc) begin
      chk(p && !q, "R9 broadcast ends at parity", {p, q}, 2);
      chk(count_o == 9'(exp_count(len)), tk ? "R5 count sender" : "R4 count listener", count_o, exp_count(len));
      chk(drive_o === 1'b1, "R9 no ack slot", drive_o, 1);
      return;
    end
    chk(!p && !q, "R7 no pulse before ack slot", {p, q}, 0);
    if (!tk) chk(drive_o === 1'b0, "R7 listener acknowledges", drive_o, 0);
    else     chk(drive_o === 1'b1, "R8 sender releases ack slot", drive_o, 1);
    if (abort_dec) begin
      strobe(tk ? nack : 1'b0, 1'b1, p, q);
      chk(!p && !q, "R12 abort beats ack decision", {p, q}, 0);
      chk(count_o == cnt_before, "R12 count unchanged", count_o, cnt_before);
      return;
    end
    strobe(tk ? nack : 1'b0, 1'b0, p, q);
    if (tk && nack) begin
      chk(q && !p, "R8 missing ack quits", {p, q}, 1);
      chk(count_o == cnt_before, "R11 count held on quit", count_o, cnt_before);
    end else begin
      chk(p && !q, tk ? "R8 ack proceeds" : "R7 proceed after ack", {p, q}, 2);
      chk(count_o == 9'(exp_count(len)), len == 0 ? "R5 zero means 256" : "R4 decoded count", count_o, exp_count(len));
    end
    @(negedge clk);
    chk(!proceed_o && !quit_o && drive_o === 1'b1, "R1 idle after field", {proceed_o, quit_o}, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic p, q;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(drive_o === 1'b1 && !proceed_o && !quit_o && count_o == 0, "R1 reset state", drive_o, 1);
    for (int k = 0; k < 3; k++) begin
      strobe(1'b0, 1'b0, p, q);
      chk(!p && !q && drive_o === 1'b1, "R10 idle strobe ignored", {p, q}, 0);
    end
    // directed corners
    run_field(1, 0, 8'h00, 0, 0, 0, 0);  // R5 sender, 256
    run_field(0, 0, 8'h00, 0, 0, 0, 0);  // R5 listener, 256
    run_field(0, 0, 8'hFF, 0, 0, 0, 0);
    run_field(1, 0, 8'h01, 0, 1, 0, 0);  // R8 nack
    run_field(0, 0, 8'hA5, 1, 0, 0, 0);  // R6
    run_field(0, 1, 8'h3C, 1, 0, 0, 0);  // R6 broadcast bad parity
    run_field(0, 1, 8'h80, 0, 0, 0, 0);  // R9 listener
    run_field(1, 1, 8'h7F, 0, 0, 0, 0);  // R9 sender
    run_field(1, 0, 8'h96, 0, 0, 1, 0);  // R10 mid start
    run_field(0, 1, 8'h12, 0, 0, 0, 1);  // R12 parity decision
    run_field(1, 0, 8'h44, 0, 0, 0, 1);  // R12 ack decision
    // abort mid field then a clean field
    @(negedge clk); start_i = 1'b1; talk_i = 1'b1; bcast_i = 1'b0; tx_len_i = 8'h55;
    @(negedge clk); start_i = 1'b0;
    strobe(1'b0, 1'b0, p, q);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk(drive_o === 1'b1, "R1 abort returns idle", drive_o, 1);
    strobe(1'b0, 1'b0, p, q);
    chk(!p && !q, "R1 strobe after abort ignored", {p, q}, 0);
    // random fields
    for (int n = 0; n < 80; n++) begin
      run_field(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 5) == 0), 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule